// File: doc/BRIEF.md
# Exception Pending Control Register

This block is a single 32-bit control and status word for a small exception controller. It keeps the pending state of three system exceptions: a non-maskable exception, a deferred-service exception meant for work that software postpones, and a periodic-tick exception. Software sets or clears these pending states by writing ones to dedicated bit positions. Bits written as zero leave the state alone. The core clears a pending state when it enters the matching handler. A non-maskable source that fires again during its handler makes the state pending once more.

Each pending state is also sent as a level to the priority arbiter. The arbiter replies with a one-cycle handler-entry strobe and the number of the exception being entered. The arbiter's view of the system is passed straight through to the read word: the active exception number, the top pending exception number, an any-interrupt-pending flag and a flag that says returning would leave nothing active. Reads are combinational and always available. A write takes effect at the next clock edge.

Top module: `excp_pend_ctl`

## Requirements
- R1: Under the synchronous active-low reset all three pending states are 0. With the status inputs at 0, `bus_rdata` reads 0x00000000.
- R2: Writing 1 to bit 31 makes the non-maskable exception pending. Writing 0 there has no effect.
- R3: A handler-entry strobe whose number equals `NMI_NUM` (default 2) clears the non-maskable pending state. A pulse on `nmi_trig` sets it again, including while the handler runs.
- R4: Writing 1 to bit 28 makes the deferred-service exception pending. Writing 1 to bit 27 clears it. A handler entry with number `DSV_NUM` (default 14) also clears it. Zeros written to either bit have no effect.
- R5: Writing 1 to bit 26 makes the tick exception pending. Writing 1 to bit 25 clears it. A handler entry with number `TICK_NUM` (default 15) also clears it. Zeros have no effect.
- R6: When one write carries both the set bit and the clear bit of the same exception, the exception ends up not pending.
- R7: When a set (a bus write, or `nmi_trig` for the non-maskable exception) arrives in the same cycle as that exception's handler entry, the exception stays pending.
- R8: A handler entry for one exception number leaves the other exceptions' pending states unchanged. Cycles with `bus_wr` low change no pending state, whatever `bus_wdata` holds.
- R9: The read word has this layout:
  - bit 31: non-maskable pending
  - bit 28: deferred-service pending
  - bit 26: tick pending
  - bit 22: `any_pend`
  - bits 20:12: `top_pend`
  - bit 11: `no_preempt`
  - bits 8:0: `cur_active`
  - bits 27 and 25, and every other bit: 0
- R10: `nmi_pend`, `dsv_pend` and `tick_pend` always equal read bits 31, 28 and 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for this register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| nmi_trig | input | 1 | Non-maskable source pulse; sets the pending state |
| entry_stb | input | 1 | One-cycle handler-entry strobe from the arbiter |
| entry_num | input | 9 | Number of the exception being entered |
| cur_active | input | 9 | Number of the active exception |
| top_pend | input | 9 | Number of the highest-priority pending exception |
| any_pend | input | 1 | Some interrupt is pending |
| no_preempt | input | 1 | No other preempted exception is active |
| nmi_pend | output | 1 | Non-maskable pending level |
| dsv_pend | output | 1 | Deferred-service pending level |
| tick_pend | output | 1 | Tick pending level |

## Verification
The assertions assume that `entry_stb` is a single-cycle pulse from the arbiter. They also assume that `entry_num` is only meaningful while that strobe is high. They assume nothing about which exception numbers the arbiter picks. To stay within these assumptions, the random stimulus raises `entry_stb` for single cycles only. It mostly draws `entry_num` from the three configured numbers and sometimes uses an unrelated number. It also pairs entries with same-cycle writes and source pulses, so the precedence cases occur often. The status inputs are free-running random values, because the block only passes them through.

// File: rtl/excp_pkg.sv
`timescale 1ns/1ps
package excp_pkg;
  localparam int REG_W = 32;
  localparam int NUM_W = 9;

  // bit positions the core and software decode
  localparam int B_NMI_SET = 31;
  localparam int B_DSV_SET = 28;
  localparam int B_DSV_CLR = 27;
  localparam int B_TCK_SET = 26;
  localparam int B_TCK_CLR = 25;
  localparam int B_ANY     = 22;
  localparam int F_TOP_LO  = 12;
  localparam int B_BASE    = 11;
  localparam int F_ACT_LO  = 0;

  typedef enum int {SRC_NMI = 0, SRC_DSV = 1, SRC_TCK = 2} src_e;
  localparam int N_SRC = 3;

  typedef struct packed {
    logic set;
    logic clr;
  } wcmd_t;
endpackage

// File: rtl/excp_wdec.sv
`timescale 1ns/1ps
module excp_wdec
  import excp_pkg::*;
(
  input  logic                        wr,
  input  logic [REG_W-1:0]            wdata,
  output wcmd_t [N_SRC-1:0]           cmd
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_comb begin
    cmd = '0;
    cmd[SRC_NMI].set = wr & wdata[B_NMI_SET];
    cmd[SRC_DSV].set = wr & wdata[B_DSV_SET];
    cmd[SRC_DSV].clr = wr & wdata[B_DSV_CLR];
    cmd[SRC_TCK].set = wr & wdata[B_TCK_SET];
    cmd[SRC_TCK].clr = wr & wdata[B_TCK_CLR];
  end
endmodule

// File: rtl/excp_flag.sv
`timescale 1ns/1ps
module excp_flag
  import excp_pkg::*;
#(
  parameter bit              HAS_CLR = 1'b1,
  parameter logic [NUM_W-1:0] EXC_NUM = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wcmd_t            cmd,
  input  logic             hw_set,
  input  logic             entry_stb,
  input  logic [NUM_W-1:0] entry_num,
  output logic             pend
);
  logic clr_eff, set_eff, hit, nxt;

  assign clr_eff = HAS_CLR & cmd.clr;
  assign set_eff = cmd.set | hw_set;
  assign hit     = entry_stb & (entry_num == EXC_NUM);

  // precedence: clear write, then set, then handler entry
  always_comb begin
    if (clr_eff)      nxt = 1'b0;
    else if (set_eff) nxt = 1'b1;
    else if (hit)     nxt = 1'b0;
    else              nxt = pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= nxt;
  end
endmodule

// File: rtl/excp_rdmux.sv
`timescale 1ns/1ps
module excp_rdmux
  import excp_pkg::*;
(
  input  logic [N_SRC-1:0] pend,
  input  logic [NUM_W-1:0] cur_active,
  input  logic [NUM_W-1:0] top_pend,
  input  logic             any_pend,
  input  logic             no_preempt,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    rdata[B_NMI_SET] = pend[SRC_NMI];
    rdata[B_DSV_SET] = pend[SRC_DSV];
    rdata[B_TCK_SET] = pend[SRC_TCK];
    rdata[B_ANY]     = any_pend;
    rdata[F_TOP_LO +: NUM_W] = top_pend;
    rdata[B_BASE]    = no_preempt;
    rdata[F_ACT_LO +: NUM_W] = cur_active;
  end
endmodule

// File: rtl/excp_pend_ctl.sv
`timescale 1ns/1ps
module excp_pend_ctl
  import excp_pkg::*;
#(
  parameter logic [NUM_W-1:0] NMI_NUM  = 9'd2,
  parameter logic [NUM_W-1:0] DSV_NUM  = 9'd14,
  parameter logic [NUM_W-1:0] TICK_NUM = 9'd15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             nmi_trig,
  input  logic             entry_stb,
  input  logic [NUM_W-1:0] entry_num,
  input  logic [NUM_W-1:0] cur_active,
  input  logic [NUM_W-1:0] top_pend,
  input  logic             any_pend,
  input  logic             no_preempt,
  output logic             nmi_pend,
  output logic             dsv_pend,
  output logic             tick_pend
);
  localparam logic [N_SRC-1:0][NUM_W-1:0] EXC_TBL = {TICK_NUM, DSV_NUM, NMI_NUM};

  wcmd_t [N_SRC-1:0] cmd;
  logic  [N_SRC-1:0] hw_set;
  logic  [N_SRC-1:0] pend;

  assign hw_set = {1'b0, 1'b0, nmi_trig};

  excp_wdec u_wdec (
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .cmd   (cmd)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    excp_flag #(
      .HAS_CLR (i != SRC_NMI),
      .EXC_NUM (EXC_TBL[i])
    ) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd[i]),
      .hw_set    (hw_set[i]),
      .entry_stb (entry_stb),
      .entry_num (entry_num),
      .pend      (pend[i])
    );
  end

  excp_rdmux u_rdmux (
    .pend       (pend),
    .cur_active (cur_active),
    .top_pend   (top_pend),
    .any_pend   (any_pend),
    .no_preempt (no_preempt),
    .rdata      (bus_rdata)
  );

  assign nmi_pend  = pend[SRC_NMI];
  assign dsv_pend  = pend[SRC_DSV];
  assign tick_pend = pend[SRC_TCK];
endmodule

// File: rtl/excp_pend_ctl_chk.sv
`timescale 1ns/1ps
module excp_pend_ctl_chk
  import excp_pkg::*;
#(
  parameter logic [NUM_W-1:0] NMI_NUM  = 9'd2,
  parameter logic [NUM_W-1:0] DSV_NUM  = 9'd14,
  parameter logic [NUM_W-1:0] TICK_NUM = 9'd15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [REG_W-1:0] bus_wdata,
  input logic [REG_W-1:0] bus_rdata,
  input logic             nmi_trig,
  input logic             entry_stb,
  input logic [NUM_W-1:0] entry_num,
  input logic             nmi_pend,
  input logic             dsv_pend,
  input logic             tick_pend
);
  // R2
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[B_NMI_SET]) |=> nmi_pend);

  // R3
  nmi_entry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && entry_num == NMI_NUM && !nmi_trig && !(bus_wr && bus_wdata[B_NMI_SET]))
      |=> !nmi_pend);

  // R6
  dsv_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[B_DSV_SET] && bus_wdata[B_DSV_CLR]) |=> !dsv_pend);

  // R6
  tick_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[B_TCK_SET] && bus_wdata[B_TCK_CLR]) |=> !tick_pend);

  // R7
  tick_set_over_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && entry_num == TICK_NUM && bus_wr && bus_wdata[B_TCK_SET] && !bus_wdata[B_TCK_CLR])
      |=> tick_pend);

  // R7
  dsv_set_over_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_stb && entry_num == DSV_NUM && bus_wr && bus_wdata[B_DSV_SET] && !bus_wdata[B_DSV_CLR])
      |=> dsv_pend);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !entry_stb && !nmi_trig) |=> $stable({nmi_pend, dsv_pend, tick_pend}));

  // R9
  clr_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[B_DSV_CLR] == 1'b0) && (bus_rdata[B_TCK_CLR] == 1'b0));

  // R10
  level_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {bus_rdata[B_NMI_SET], bus_rdata[B_DSV_SET], bus_rdata[B_TCK_SET]} ==
    {nmi_pend, dsv_pend, tick_pend});
endmodule

bind excp_pend_ctl excp_pend_ctl_chk #(
  .NMI_NUM  (NMI_NUM),
  .DSV_NUM  (DSV_NUM),
  .TICK_NUM (TICK_NUM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .nmi_trig  (nmi_trig),
  .entry_stb (entry_stb),
  .entry_num (entry_num),
  .nmi_pend  (nmi_pend),
  .dsv_pend  (dsv_pend),
  .tick_pend (tick_pend)
);

// File: tb/excp_pend_ctl_test.sv
`timescale 1ns/1ps
module excp_pend_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nmi_trig = 1'b0;
  logic        entry_stb = 1'b0;
  logic [8:0]  entry_num = '0;
  logic [8:0]  cur_active = '0;
  logic [8:0]  top_pend = '0;
  logic        any_pend = 1'b0;
  logic        no_preempt = 1'b0;
  logic        nmi_pend, dsv_pend, tick_pend;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  logic [2:0] mf = '0; // model flags {tick, dsv, nmi}

  always #2 clk = ~clk;

  excp_pend_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nmi_trig(nmi_trig), .entry_stb(entry_stb),
    .entry_num(entry_num), .cur_active(cur_active), .top_pend(top_pend),
    .any_pend(any_pend), .no_preempt(no_preempt), .nmi_pend(nmi_pend),
    .dsv_pend(dsv_pend), .tick_pend(tick_pend)
  );

  function automatic logic step_flag(logic cur, logic set, logic clr, logic hit);
    if (clr) return 1'b0;
    if (set) return 1'b1;
    if (hit) return 1'b0;
    return cur;
  endfunction

  function automatic logic [2:0] model_next(logic [2:0] f, logic wr, logic [31:0] wd,
                                            logic trig, logic stb, logic [8:0] num);
    logic [2:0] n;
    n[0] = step_flag(f[0], (wr & wd[31]) | trig, 1'b0, stb && num == 9'd2);
    n[1] = step_flag(f[1], wr & wd[28], wr & wd[27], stb && num == 9'd14);
    n[2] = step_flag(f[2], wr & wd[26], wr & wd[25], stb && num == 9'd15);
    return n;
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] f, logic [8:0] act, logic [8:0] top,
                                           logic any, logic base);
    logic [31:0] r = '0;
    r[31] = f[0]; r[28] = f[1]; r[26] = f[2];
    r[22] = any; r[20:12] = top; r[11] = base; r[8:0] = act;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after the edge
  task automatic cyc(logic wr, logic [31:0] wd, logic trig, logic stb, logic [8:0] num);
    @(negedge clk);
    bus_wr = wr; bus_wdata = wd; nmi_trig = trig; entry_stb = stb; entry_num = num;
    @(posedge clk);
    mf = model_next(mf, wr, wd, trig, stb, num);
    #1;
    bus_wr = 1'b0; nmi_trig = 1'b0; entry_stb = 1'b0;
    chk("R9 read word", bus_rdata, exp_read(mf, cur_active, top_pend, any_pend, no_preempt));
    chk("R10 levels", {29'd0, tick_pend, dsv_pend, nmi_pend}, {29'd0, mf});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset read", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", bus_rdata, 32'h0);

    cyc(1, 32'h8000_0000, 0, 0, 0); chk("R2 nmi set", {31'd0, nmi_pend}, 32'd1);
    cyc(1, 32'h0000_0000, 0, 0, 0); chk("R2 zero write", {31'd0, nmi_pend}, 32'd1);
    cyc(0, 32'h0, 0, 1, 9'd2);      chk("R3 entry clears", {31'd0, nmi_pend}, 32'd0);
    cyc(0, 32'h0, 1, 0, 0);         chk("R3 retrigger", {31'd0, nmi_pend}, 32'd1);
    cyc(0, 32'h0, 1, 1, 9'd2);      chk("R7 trig over entry", {31'd0, nmi_pend}, 32'd1);
    cyc(1, 32'h1000_0000, 0, 0, 0); chk("R4 dsv set", {31'd0, dsv_pend}, 32'd1);
    cyc(1, 32'h0800_0000, 0, 0, 0); chk("R4 dsv clear", {31'd0, dsv_pend}, 32'd0);
    cyc(1, 32'h0400_0000, 0, 0, 0); chk("R5 tick set", {31'd0, tick_pend}, 32'd1);
    cyc(1, 32'h0200_0000, 0, 0, 0); chk("R5 tick clear", {31'd0, tick_pend}, 32'd0);
    cyc(1, 32'h1000_0000, 0, 0, 0);
    cyc(1, 32'h1800_0000, 0, 0, 0); chk("R6 dsv both", {31'd0, dsv_pend}, 32'd0);
    cyc(1, 32'h0600_0000, 0, 0, 0); chk("R6 tick both", {31'd0, tick_pend}, 32'd0);
    cyc(1, 32'h0400_0000, 0, 0, 0);
    cyc(1, 32'h0400_0000, 0, 1, 9'd15); chk("R7 write over entry", {31'd0, tick_pend}, 32'd1);
    cyc(0, 32'h0, 0, 1, 9'd14);     chk("R8 other entry", {31'd0, tick_pend}, 32'd1);
    cyc(0, 32'h0, 0, 1, 9'd15);     chk("R5 tick entry", {31'd0, tick_pend}, 32'd0);
    cyc(0, 32'hFFFF_FFFF, 0, 0, 0); chk("R8 no strobe", {29'd0, tick_pend, dsv_pend, nmi_pend}, 32'd1);

    @(negedge clk);
    cur_active = 9'h1A5; top_pend = 9'h0C3; any_pend = 1'b1; no_preempt = 1'b1;
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0); chk("R9 layout", bus_rdata, 32'h804C_39A5);
    cyc(1, 32'h1000_0000, 0, 0, 0); chk("R9 clear pos zero", {30'd0, bus_rdata[28:27]}, 32'd2);

    for (int n = 0; n < 3000; n++) begin
      logic        w;
      logic [31:0] d;
      logic        s;
      logic [8:0]  en;
      int          pick;
      w = ($urandom % 2) == 0;
      d = $urandom & 32'h9E00_0000 | ($urandom & 32'h61FF_FFFF);
      s = ($urandom % 4) == 0;
      pick = $urandom % 4;
      en = (pick == 0) ? 9'd2 : (pick == 1) ? 9'd14 : (pick == 2) ? 9'd15 : 9'($urandom);
      @(negedge clk);
      cur_active = 9'($urandom); top_pend = 9'($urandom);
      any_pend = 1'($urandom); no_preempt = 1'($urandom);
      cyc(w, d, ($urandom % 8) == 0, s, en);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule